// File: doc/BRIEF.md
# Enable-Protected DMA Configuration Register File

This block is the configuration register file of a multi-channel DMA controller that also contains a CRC unit. A simple synchronous bus slave reaches it through an address, write data, a write strobe and a combinational read-data port. The block refuses writes to configuration state that the running engine depends on. It decides register by register, and sometimes field by field, using the live controller enable, the CRC enable and each channel's own enable.

Global state includes the descriptor base address, the write-back base address, one enable per priority level, the controller enable, the CRC enable and a self-clearing soft reset. Per-channel control registers are reached indirectly through a channel-select register. The CRC control and checksum registers also live here. When any part of a write is refused, the block raises a one-cycle write-ignored flag. Software clears the relevant enable, reconfigures, and then enables again.

Top module: `dma_cfg_regs`

## Requirements
- R1: The descriptor base (offset 1) and write-back base (offset 2) registers take a write only while the controller enable is 0. Otherwise the value is kept.
- R2: The enable bits can be written at any time. In GCTL (offset 0) these are bit 1 (controller enable), bit 2 (CRC enable) and bits 8 and up (one per priority level). In CH_CTLA (offset 4) this is bit 1 (channel enable).
- R3: Writing 1 to GCTL bit 0 while both the controller and CRC enables are 0 returns every register to 0 on the next edge, including the channel registers and the channel select. The bit always reads 0. If either enable is 1, the soft reset is refused and the other GCTL fields are still written.
- R4: CH_CTLB (offset 5) holds trigger source [5:0], trigger action [9:8], priority level [13:12] and command [17:16]. While the selected channel is enabled, trigger source and trigger action keep their values, while level and command are still written.
- R5: Writing 1 to CH_CTLA bit 0 clears only the selected channel's registers, and only if that channel is disabled. Otherwise the soft reset is refused and the enable bit is still written.
- R6: CRC control (offset 6: beat size [1:0], polynomial [3:2], input source [13:8]) and CRC checksum (offset 7) take writes only while the CRC enable is 0.
- R7: CH_CTLA and CH_CTLB read and write the channel named by CH_SEL (offset 3). Other channels are untouched.
- R8: wr_ignored is 1 in the cycle after a write of which any part was refused, and 0 otherwise.
- R9: Protection uses the enable values held before the write. An enable set by one write first protects the following access.
- R10: Reads are never gated, and read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DW | Read data |
| wr_ignored | output | 1 | Pulses after a (partly) refused write |

## Verification
The bench builds the block with its defaults: four channels, four priority levels and 32-bit data. With these values the two-bit channel select reaches every channel, and channels 1 and 2 can be shown to hold independent state. Protected fields are driven while each enable is set and again after it is cleared. Both soft resets are exercised, including the case where one write sets the CRC enable together with the global soft reset.

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int NCH  = 4,
  parameter int NLVL = 4,
  parameter int DW   = 32,
  parameter int TSW  = 6,
  parameter int TAW  = 2,
  parameter int CMDW = 2,
  parameter int CSW  = 6,
  parameter int CPW  = 2,
  parameter int CBW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          wr_ignored
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LVW = (NLVL > 1) ? $clog2(NLVL) : 1;
  localparam logic [2:0] A_GCTL = 3'd0, A_DESC = 3'd1, A_WB = 3'd2, A_SEL = 3'd3;
  localparam logic [2:0] A_CHA = 3'd4, A_CHB = 3'd5, A_CRCC = 3'd6, A_SUM = 3'd7;

  logic            dma_en, crc_en;
  logic [NLVL-1:0] lvl_en;
  logic [DW-1:0]   desc_base, wb_base, crc_sum;
  logic [CHW-1:0]  ch_sel;
  logic [CSW-1:0]  crc_src;
  logic [CPW-1:0]  crc_poly;
  logic [CBW-1:0]  crc_beat;

  logic [NCH-1:0]  ch_en;
  logic [TSW-1:0]  trig_src [NCH];
  logic [TAW-1:0]  trig_act [NCH];
  logic [LVW-1:0]  ch_lvl   [NCH];
  logic [CMDW-1:0] ch_cmd   [NCH];

  wire w_gctl = bus_we && bus_addr == A_GCTL;
  wire w_desc = bus_we && bus_addr == A_DESC;
  wire w_wb   = bus_we && bus_addr == A_WB;
  wire w_sel  = bus_we && bus_addr == A_SEL;
  wire w_cha  = bus_we && bus_addr == A_CHA;
  wire w_chb  = bus_we && bus_addr == A_CHB;
  wire w_crcc = bus_we && bus_addr == A_CRCC;
  wire w_sum  = bus_we && bus_addr == A_SUM;

  wire sel_en  = ch_en[ch_sel];
  wire g_srst  = w_gctl && bus_wdata[0] && !dma_en && !crc_en;
  wire c_srst  = w_cha && bus_wdata[0] && !sel_en;

  wire blocked = (w_gctl && bus_wdata[0] && (dma_en || crc_en))
              || ((w_desc || w_wb) && dma_en)
              || ((w_crcc || w_sum) && crc_en)
              || (w_chb && sel_en)
              || (w_cha && bus_wdata[0] && sel_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0; crc_en <= 1'b0; lvl_en <= '0;
      desc_base <= '0; wb_base <= '0; crc_sum <= '0; ch_sel <= '0;
      crc_src <= '0; crc_poly <= '0; crc_beat <= '0;
      wr_ignored <= 1'b0;
    end else if (g_srst) begin
      dma_en <= 1'b0; crc_en <= 1'b0; lvl_en <= '0;
      desc_base <= '0; wb_base <= '0; crc_sum <= '0; ch_sel <= '0;
      crc_src <= '0; crc_poly <= '0; crc_beat <= '0;
      wr_ignored <= 1'b0;
    end else begin
      wr_ignored <= blocked;
      if (w_gctl) begin
        dma_en <= bus_wdata[1];
        crc_en <= bus_wdata[2];
        lvl_en <= bus_wdata[8 +: NLVL];
      end
      if (w_desc && !dma_en) desc_base <= bus_wdata;
      if (w_wb && !dma_en)   wb_base   <= bus_wdata;
      if (w_sel)             ch_sel    <= bus_wdata[CHW-1:0];
      if (w_sum && !crc_en)  crc_sum   <= bus_wdata;
      if (w_crcc && !crc_en) begin
        crc_beat <= bus_wdata[0 +: CBW];
        crc_poly <= bus_wdata[2 +: CPW];
        crc_src  <= bus_wdata[8 +: CSW];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            en_q;
    logic [TSW-1:0]  src_q;
    logic [TAW-1:0]  act_q;
    logic [LVW-1:0]  lvl_q;
    logic [CMDW-1:0] cmd_q;
    wire hit = ch_sel == CHW'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; src_q <= '0; act_q <= '0; lvl_q <= '0; cmd_q <= '0;
      end else if (g_srst || (c_srst && hit)) begin
        en_q <= 1'b0; src_q <= '0; act_q <= '0; lvl_q <= '0; cmd_q <= '0;
      end else begin
        if (w_cha && hit) en_q <= bus_wdata[1];
        if (w_chb && hit) begin
          lvl_q <= bus_wdata[12 +: LVW];
          cmd_q <= bus_wdata[16 +: CMDW];
          if (!en_q) begin
            src_q <= bus_wdata[0 +: TSW];
            act_q <= bus_wdata[8 +: TAW];
          end
        end
      end
    end

    assign ch_en[c]    = en_q;
    assign trig_src[c] = src_q;
    assign trig_act[c] = act_q;
    assign ch_lvl[c]   = lvl_q;
    assign ch_cmd[c]   = cmd_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GCTL: begin
        bus_rdata[1] = dma_en;
        bus_rdata[2] = crc_en;
        bus_rdata[8 +: NLVL] = lvl_en;
      end
      A_DESC: bus_rdata = desc_base;
      A_WB:   bus_rdata = wb_base;
      A_SEL:  bus_rdata[0 +: CHW] = ch_sel;
      A_CHA:  bus_rdata[1] = sel_en;
      A_CHB: begin
        bus_rdata[0 +: TSW]   = trig_src[ch_sel];
        bus_rdata[8 +: TAW]   = trig_act[ch_sel];
        bus_rdata[12 +: LVW]  = ch_lvl[ch_sel];
        bus_rdata[16 +: CMDW] = ch_cmd[ch_sel];
      end
      A_CRCC: begin
        bus_rdata[0 +: CBW] = crc_beat;
        bus_rdata[2 +: CPW] = crc_poly;
        bus_rdata[8 +: CSW] = crc_src;
      end
      default: bus_rdata = crc_sum;
    endcase
  end
endmodule

// File: rtl/dma_cfg_regs_chk.sv
module dma_cfg_regs_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          wr_ignored,
  input logic          dma_en,
  input logic          crc_en,
  input logic [DW-1:0] desc_base,
  input logic [DW-1:0] crc_sum
);
  p_desc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd1 && dma_en |=> $stable(desc_base));

  p_base_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd1 && dma_en |=> wr_ignored);

  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd0 && !bus_wdata[0]
      |=> dma_en == $past(bus_wdata[1]) && crc_en == $past(bus_wdata[2]));

  p_srst_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd0 && bus_wdata[0] && (dma_en || crc_en) |=> wr_ignored);

  p_srst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd0 && bus_wdata[0] && !dma_en && !crc_en
      |=> desc_base == '0 && !dma_en && !crc_en && crc_sum == '0);

  p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 3'd7 && crc_en |=> $stable(crc_sum));

  p_flag_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> !wr_ignored);
endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(.DW(DW)) u_chk (
  .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .wr_ignored,
  .dma_en, .crc_en, .desc_base, .crc_sum
);

// File: tb/sim_dma_cfg_regs.sv
module sim_dma_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        wr_ignored;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  dma_cfg_regs u0 (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata, .wr_ignored);

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1ns d = bus_rdata;
  endtask

  // {read, requirement, addr, data or expected, expected flag}
  localparam int NV = 30;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 4'd1, 3'd1, 32'h1000_0000, 1'b0},
    {1'b1, 4'd10, 3'd1, 32'h1000_0000, 1'b0},  // R10
    {1'b0, 4'd1, 3'd2, 32'h2000_0040, 1'b0},
    {1'b0, 4'd2, 3'd0, 32'h0000_0F02, 1'b0},   // R2
    {1'b1, 4'd2, 3'd0, 32'h0000_0F02, 1'b0},
    {1'b0, 4'd1, 3'd1, 32'h0000_DEAD, 1'b1},   // R1 blocked
    {1'b1, 4'd1, 3'd1, 32'h1000_0000, 1'b0},
    {1'b0, 4'd1, 3'd2, 32'h0000_0001, 1'b1},
    {1'b1, 4'd1, 3'd2, 32'h2000_0040, 1'b0},
    {1'b0, 4'd3, 3'd0, 32'h0000_0F03, 1'b1},   // R3 refused
    {1'b1, 4'd3, 3'd0, 32'h0000_0F02, 1'b0},
    {1'b0, 4'd7, 3'd3, 32'h0000_0001, 1'b0},   // R7
    {1'b0, 4'd4, 3'd5, 32'h0001_212A, 1'b0},   // R4
    {1'b1, 4'd4, 3'd5, 32'h0001_212A, 1'b0},
    {1'b0, 4'd2, 3'd4, 32'h0000_0002, 1'b0},
    {1'b0, 4'd4, 3'd5, 32'h0002_3305, 1'b1},
    {1'b1, 4'd4, 3'd5, 32'h0002_312A, 1'b0},
    {1'b0, 4'd5, 3'd4, 32'h0000_0003, 1'b1},   // R5 refused
    {1'b1, 4'd5, 3'd4, 32'h0000_0002, 1'b0},
    {1'b0, 4'd7, 3'd3, 32'h0000_0002, 1'b0},
    {1'b1, 4'd7, 3'd5, 32'h0000_0000, 1'b0},
    {1'b0, 4'd7, 3'd5, 32'h0000_0115, 1'b0},
    {1'b1, 4'd7, 3'd5, 32'h0000_0115, 1'b0},
    {1'b0, 4'd2, 3'd0, 32'h0000_0F06, 1'b0},
    {1'b0, 4'd6, 3'd6, 32'h0000_3F0F, 1'b1},   // R6
    {1'b1, 4'd6, 3'd6, 32'h0000_0000, 1'b0},
    {1'b0, 4'd6, 3'd0, 32'h0000_0F02, 1'b0},
    {1'b0, 4'd6, 3'd6, 32'h0000_2A06, 1'b0},
    {1'b1, 4'd6, 3'd6, 32'h0000_2A06, 1'b0},
    {1'b0, 4'd6, 3'd7, 32'hFFFF_FFFF, 1'b0}
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, d); chk(3, d, 32'h0, "reset GCTL");
    rd(3'd1, d); chk(3, d, 32'h0, "reset DESC");
    chk(8, {31'b0, wr_ignored}, 32'h0, "reset flag");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        rd(VEC[i][35:33], d);
        chk(int'(VEC[i][39:36]), d, VEC[i][32:1], $sformatf("vector %0d read", i));
      end else begin
        wr(VEC[i][35:33], VEC[i][32:1]);
        chk(8, {31'b0, wr_ignored}, {31'b0, VEC[i][0]}, $sformatf("vector %0d flag", i));
      end
    end

    // R8: flag lasts one cycle only
    wr(3'd1, 32'h5);
    chk(8, {31'b0, wr_ignored}, 32'h1, "flag after blocked write");
    @(negedge clk);
    chk(8, {31'b0, wr_ignored}, 32'h0, "flag cleared next cycle");

    // R9: the write that sets the CRC enable is not itself protected
    wr(3'd0, 32'h0000_0F02);
    wr(3'd0, 32'h0000_0F06);
    wr(3'd7, 32'h1234_5678);
    chk(9, {31'b0, wr_ignored}, 32'h1, "sum refused after crc enable");
    rd(3'd7, d); chk(9, d, 32'hFFFF_FFFF, "sum kept");

    // R5: channel soft reset touches only the selected channel
    wr(3'd3, 32'h2);
    wr(3'd4, 32'h1);
    chk(5, {31'b0, wr_ignored}, 32'h0, "channel 2 reset accepted");
    rd(3'd5, d); chk(5, d, 32'h0, "channel 2 cleared");
    wr(3'd3, 32'h1);
    rd(3'd5, d); chk(5, d, 32'h0002_312A, "channel 1 untouched");

    // R3 and R9: soft reset together with setting the CRC enable, both enables 0 before
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0000_0005);
    chk(3, {31'b0, wr_ignored}, 32'h0, "srst accepted");
    rd(3'd0, d); chk(3, d, 32'h0, "GCTL after srst");
    rd(3'd1, d); chk(3, d, 32'h0, "DESC after srst");
    rd(3'd7, d); chk(3, d, 32'h0, "SUM after srst");
    rd(3'd3, d); chk(3, d, 32'h0, "SEL after srst");
    wr(3'd3, 32'h1);
    rd(3'd5, d); chk(3, d, 32'h0, "channel 1 after srst");
    rd(3'd4, d); chk(3, d, 32'h0, "channel 1 enable after srst");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule